// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block keeps a bank of 32 message mailboxes and decides which waiting transmit mailbox is handed next to a frame-sending engine. Software fills a mailbox through a simple register port. The mailbox holds an identifier word, a control word and two data words. Software then sets the mailbox's bit in the request-set register. Each mailbox carries a 6-bit priority in its control word. The largest priority value wins arbitration. When priorities are equal, the higher mailbox number wins.

The frame engine sits behind a start/done handshake. When the engine is idle and at least one mailbox qualifies, the arbiter latches the winner's index and pulses a start strobe. It then presents that mailbox's four words and holds them until the engine reports done. On done, the mailbox's acknowledge bit is set and its pending bit is dropped in the same cycle. A one-hot completion pulse names the finished mailbox. Software clears acknowledge bits by writing ones.

Register map (byte addresses, 10-bit address): 0x000 enable bitmap, 0x004 direction bitmap (1 = receive), 0x008 request-set on write and pending bitmap on read, 0x00C acknowledge bitmap (write 1 to clear). Mailbox n word w is at 0x200 + 16n + 4w, where w = 0 is the identifier, 1 is control, 2 is data low and 3 is data high. In the identifier, bit 31 flags an extended identifier, and a standard 11-bit identifier sits at bits 28:18. In the control word, the length code is in bits 3:0, the remote flag in bit 4 and the priority in bits 13:8.

Top module: `can_tx_arb`

## Requirements
- R1: After reset the enable, direction, pending and acknowledge bitmaps read 0, and txBusy, txStart and txCompleteVec are 0.
- R2: A write to 0x008 sets the pending bit of every mailbox whose data bit is 1. Zero bits leave pending bits unchanged. Pending bits never rise without such a write.
- R3: Among qualifying mailboxes, the one with the largest control-word priority (bits 13:8) is started first.
- R4: When the largest priority is shared, the highest-numbered mailbox among them is started.
- R5: A mailbox qualifies only when its enable bit is 1, its direction bit is 0 and its pending bit is 1.
- R6: txStart is a single-cycle pulse in the first busy cycle. txIdx and txBusy hold steady until txDone, even if requests or priorities change meanwhile.
- R7: txDone while busy sets that mailbox's acknowledge bit and clears its pending bit at the same clock edge. txCompleteVec carries a one-cycle, one-hot pulse for that mailbox in the next cycle.
- R8: Writing 1 to a bit of 0x008's neighbour 0x00C clears that acknowledge bit. Zero bits leave it unchanged. Acknowledge bits fall only through such a write.
- R9: Clearing a pending mailbox's enable bit while the engine is busy keeps it out of the next arbitration. Re-enabling it lets it compete again.
- R10: While busy, txId, txCtrl, txDataLo and txDataHi equal the four words stored in mailbox txIdx, and the same words read back at their mailbox addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 10 | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | 10 | Read byte address |
| rdData | output | 32 | Read data (combinational) |
| txStart | output | 1 | One-cycle start pulse to the frame engine |
| txBusy | output | 1 | Engine owns the selected mailbox |
| txIdx | output | 5 | Selected mailbox index |
| txId | output | 32 | Identifier word of the selected mailbox |
| txCtrl | output | 32 | Control word of the selected mailbox |
| txDataLo | output | 32 | Low data word of the selected mailbox |
| txDataHi | output | 32 | High data word of the selected mailbox |
| txDone | input | 1 | Frame finished by the engine |
| txCompleteVec | output | 32 | One-hot completion pulse per mailbox |

## Verification
Several rules are checked on every clock: pending bits rise only through a request-set write, and acknowledge bits fall only through an acknowledge write. The bench also checks that acknowledge set and pending clear land together on done, that the index holds while busy, that start is a single pulse from a qualifying mailbox, and that completion is one-hot. Which mailbox wins is a relation over 32 priority fields, and only the bench's scenarios show it. These scenarios cover distinct priorities, ties, receive-direction and disabled mailboxes, and an enable removed while another frame is in flight. The identity of the delivered words also rests on those scenarios.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  localparam int NUM_MB   = 32;
  localparam int IDX_W    = $clog2(NUM_MB);
  localparam int WORDS    = 4;
  localparam int WORD_W   = $clog2(WORDS);
  localparam int ADDR_W   = 10;
  localparam int PRIO_W   = 6;
  localparam int PRIO_LSB = 8;
  localparam int MB_BIT   = ADDR_W - 1;
  localparam int W_ID     = 0;
  localparam int W_CTRL   = 1;
  localparam int W_LO     = 2;
  localparam int W_HI     = 3;
  localparam logic [2:0] REG_EN  = 3'd0;
  localparam logic [2:0] REG_DIR = 3'd1;
  localparam logic [2:0] REG_REQ = 3'd2;
  localparam logic [2:0] REG_ACK = 3'd3;

  typedef struct packed {
    logic             ack;
    logic [IDX_W-1:0] idx;
  } dpStrobeT;
endpackage

// File: rtl/mbox_dp.sv
module mbox_dp
  import can_arb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [31:0]                   wrData,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [31:0]                   rdData,
  input  dpStrobeT                      stb,
  input  logic [IDX_W-1:0]              selIdx,
  output logic [NUM_MB-1:0]             candMask,
  output logic [NUM_MB-1:0][PRIO_W-1:0] prioVec,
  output logic [31:0]                   txId,
  output logic [31:0]                   txCtrl,
  output logic [31:0]                   txDataLo,
  output logic [31:0]                   txDataHi
);
  logic [NUM_MB-1:0] enQ, dirQ, pendQ, ackQ;
  logic [NUM_MB-1:0] enN, dirN, pendN, ackN;
  logic [31:0] mbWords [NUM_MB][WORDS];

  logic       regWr, mbWr;
  logic [2:0] regSel;
  assign regWr  = wrEn && !wrAddr[MB_BIT];
  assign mbWr   = wrEn && wrAddr[MB_BIT];
  assign regSel = wrAddr[4:2];

  always_comb begin
    enN   = enQ;
    dirN  = dirQ;
    pendN = pendQ;
    ackN  = ackQ;
    if (regWr) begin
      case (regSel)
        REG_EN:  enN   = wrData[NUM_MB-1:0];
        REG_DIR: dirN  = wrData[NUM_MB-1:0];
        REG_REQ: pendN = pendQ | wrData[NUM_MB-1:0];
        REG_ACK: ackN  = ackQ & ~wrData[NUM_MB-1:0];
        default: ;
      endcase
    end
    if (stb.ack) begin
      pendN[stb.idx] = 1'b0;
      ackN[stb.idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= '0;
      dirQ  <= '0;
      pendQ <= '0;
      ackQ  <= '0;
    end else begin
      enQ   <= enN;
      dirQ  <= dirN;
      pendQ <= pendN;
      ackQ  <= ackN;
    end
  end

  always_ff @(posedge clk) begin
    if (mbWr) mbWords[wrAddr[IDX_W+3:4]][wrAddr[WORD_W+1:2]] <= wrData;
  end

  assign candMask = enQ & ~dirQ & pendQ;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_prio
    assign prioVec[g] = mbWords[g][W_CTRL][PRIO_LSB +: PRIO_W];
  end

  assign txId     = mbWords[selIdx][W_ID];
  assign txCtrl   = mbWords[selIdx][W_CTRL];
  assign txDataLo = mbWords[selIdx][W_LO];
  assign txDataHi = mbWords[selIdx][W_HI];

  always_comb begin
    rdData = '0;
    if (rdAddr[MB_BIT]) begin
      rdData = mbWords[rdAddr[IDX_W+3:4]][rdAddr[WORD_W+1:2]];
    end else begin
      case (rdAddr[4:2])
        REG_EN:  rdData = 32'(enQ);
        REG_DIR: rdData = 32'(dirQ);
        REG_REQ: rdData = 32'(pendQ);
        REG_ACK: rdData = 32'(ackQ);
        default: rdData = '0;
      endcase
    end
  end

  // R7
  ack_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> (ackQ[$past(stb.idx)] && !pendQ[$past(stb.idx)]));
  // R2
  req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regSel == REG_REQ) |=> ((pendQ & ~$past(pendQ)) == '0));
  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regSel == REG_ACK) |=> ((~ackQ & $past(ackQ)) == '0));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import can_arb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MB-1:0]             candMask,
  input  logic [NUM_MB-1:0][PRIO_W-1:0] prioVec,
  input  logic                          txDone,
  output dpStrobeT                      stb,
  output logic                          txStart,
  output logic                          txBusy,
  output logic [IDX_W-1:0]              txIdx,
  output logic [NUM_MB-1:0]             txCompleteVec
);
  typedef enum logic {ST_IDLE, ST_BUSY} stateT;
  stateT state;

  logic              found;
  logic [IDX_W-1:0]  winIdx;
  logic [PRIO_W-1:0] winPrio;
  logic              startQ;
  logic [NUM_MB-1:0] complQ;

  // ascending scan with >= lets the higher index take equal priority
  always_comb begin
    found   = 1'b0;
    winIdx  = '0;
    winPrio = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (candMask[i] && (!found || prioVec[i] >= winPrio)) begin
        found   = 1'b1;
        winIdx  = IDX_W'(i);
        winPrio = prioVec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      txIdx  <= '0;
      startQ <= 1'b0;
      complQ <= '0;
    end else begin
      startQ <= 1'b0;
      complQ <= '0;
      case (state)
        ST_IDLE: if (found) begin
          state  <= ST_BUSY;
          txIdx  <= winIdx;
          startQ <= 1'b1;
        end
        ST_BUSY: if (txDone) begin
          state  <= ST_IDLE;
          complQ <= NUM_MB'(1) << txIdx;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txBusy        = (state == ST_BUSY);
  assign txStart       = startQ;
  assign txCompleteVec = complQ;
  assign stb.ack       = txBusy && txDone;
  assign stb.idx       = txIdx;

  logic [NUM_MB-1:0] candPrevQ;
  always_ff @(posedge clk) begin
    if (!rstN) candPrevQ <= '0;
    else       candPrevQ <= candMask;
  end

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !txDone) |=> ($stable(txIdx) && txBusy));
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);
  // R5
  start_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txBusy && candPrevQ[txIdx]));
  // R7
  cmpl_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txCompleteVec));
endmodule

// File: rtl/can_tx_arb.sv
module can_tx_arb
  import can_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [9:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [9:0]        rdAddr,
  output logic [31:0]       rdData,
  output logic              txStart,
  output logic              txBusy,
  output logic [4:0]        txIdx,
  output logic [31:0]       txId,
  output logic [31:0]       txCtrl,
  output logic [31:0]       txDataLo,
  output logic [31:0]       txDataHi,
  input  logic              txDone,
  output logic [31:0]       txCompleteVec
);
  dpStrobeT                      stb;
  logic [NUM_MB-1:0]             candMask;
  logic [NUM_MB-1:0][PRIO_W-1:0] prioVec;

  mbox_dp i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .stb(stb), .selIdx(txIdx),
    .candMask(candMask), .prioVec(prioVec), .txId(txId), .txCtrl(txCtrl),
    .txDataLo(txDataLo), .txDataHi(txDataHi)
  );

  mbox_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .candMask(candMask), .prioVec(prioVec),
    .txDone(txDone), .stb(stb), .txStart(txStart), .txBusy(txBusy),
    .txIdx(txIdx), .txCompleteVec(txCompleteVec)
  );
endmodule

// File: tb/test_can_tx_arb.sv
module test_can_tx_arb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [9:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        txStart, txBusy, txDone = 1'b0;
  logic [4:0]  txIdx;
  logic [31:0] txId, txCtrl, txDataLo, txDataHi, txCompleteVec;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  can_tx_arb i_can_tx_arb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .txStart(txStart), .txBusy(txBusy),
    .txIdx(txIdx), .txId(txId), .txCtrl(txCtrl), .txDataLo(txDataLo),
    .txDataHi(txDataHi), .txDone(txDone), .txCompleteVec(txCompleteVec)
  );

  localparam logic [9:0] A_EN = 10'h000, A_DIR = 10'h004, A_REQ = 10'h008, A_ACK = 10'h00C;

  typedef struct packed {
    logic [4:0] a; logic [5:0] pa;
    logic [4:0] b; logic [5:0] pb;
    logic [4:0] c; logic [5:0] pc;
    logic [4:0] exp; logic tie;
  } vecT;

  localparam vecT VECS [5] = '{
    '{5'd3,  6'd10, 5'd7,  6'd20, 5'd12, 6'd5,  5'd7,  1'b0},
    '{5'd3,  6'd9,  5'd20, 6'd9,  5'd8,  6'd9,  5'd20, 1'b1},
    '{5'd31, 6'd0,  5'd0,  6'd63, 5'd15, 6'd62, 5'd0,  1'b0},
    '{5'd5,  6'd63, 5'd6,  6'd63, 5'd4,  6'd1,  5'd6,  1'b1},
    '{5'd1,  6'd1,  5'd2,  6'd0,  5'd30, 6'd0,  5'd1,  1'b0}
  };

  function automatic logic [9:0] mbAddr(int n, int w);
    return 10'(10'h200 + n * 16 + w * 4);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitStart(output int idx, output bit ok);
    ok = 0; idx = 0;
    for (int k = 0; k < 40; k++) begin
      if (txStart) begin ok = 1; idx = int'(txIdx); return; end
      @(negedge clk);
    end
  endtask

  task automatic finishFrame(int idx);
    logic [31:0] v;
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
    // R7: completion pulse, acknowledge set, pending cleared
    check(txCompleteVec == (32'd1 << idx), "R7 completion", txCompleteVec, 32'd1 << idx);
    rd(A_ACK, v);
    check(v[idx] == 1'b1, "R7 ack set", v, 32'd1 << idx);
    rd(A_REQ, v);
    check(v[idx] == 1'b0, "R7 pending cleared", v, 32'd0);
  endtask

  task automatic drain();
    int idx; bit ok;
    for (int k = 0; k < 40; k++) begin
      waitStart(idx, ok);
      if (!ok) return;
      txDone = 1'b1;
      @(negedge clk);
      txDone = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int idx; bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_EN, v);  check(v == 0, "R1 enable", v, 0);
    rd(A_DIR, v); check(v == 0, "R1 direction", v, 0);
    rd(A_REQ, v); check(v == 0, "R1 pending", v, 0);
    rd(A_ACK, v); check(v == 0, "R1 ack", v, 0);
    check(!txBusy && !txStart && txCompleteVec == 0, "R1 engine idle",
          {30'd0, txBusy, txStart}, 0);

    // R2 zero write is a no-op
    wr(A_REQ, 32'd0);
    rd(A_REQ, v); check(v == 0, "R2 zero request", v, 0);

    // table walk: R3 / R4
    foreach (VECS[n]) begin
      vecT t = VECS[n];
      wr(mbAddr(t.a, 1), {18'd0, t.pa, 8'd8});
      wr(mbAddr(t.b, 1), {18'd0, t.pb, 8'd8});
      wr(mbAddr(t.c, 1), {18'd0, t.pc, 8'd8});
      wr(A_EN, (32'd1 << t.a) | (32'd1 << t.b) | (32'd1 << t.c));
      wr(A_REQ, (32'd1 << t.a) | (32'd1 << t.b) | (32'd1 << t.c));
      waitStart(idx, ok);
      check(ok && idx == int'(t.exp), t.tie ? "R4 tie winner" : "R3 priority winner",
            32'(idx), 32'(t.exp));
      finishFrame(idx);
      drain();
      wr(A_ACK, 32'hFFFF_FFFF);
      rd(A_ACK, v); check(v == 0, "R8 ack clear", v, 0);
      wr(A_EN, 32'd0);
    end

    // R10 word delivery and readback
    wr(mbAddr(25, 0), 32'h123 << 18);
    wr(mbAddr(25, 1), 32'h0000_0514);
    wr(mbAddr(25, 2), 32'hDEAD_BEEF);
    wr(mbAddr(25, 3), 32'h0BAD_F00D);
    rd(mbAddr(25, 2), v); check(v == 32'hDEAD_BEEF, "R10 readback", v, 32'hDEAD_BEEF);
    wr(A_EN, 32'd1 << 25);
    wr(A_REQ, 32'd1 << 25);
    waitStart(idx, ok);
    check(ok && idx == 25, "R10 start", 32'(idx), 25);
    check(txId == (32'h123 << 18) && txCtrl == 32'h0000_0514, "R10 id/ctrl", txId, 32'h123 << 18);
    check(txDataLo == 32'hDEAD_BEEF && txDataHi == 32'h0BAD_F00D, "R10 data", txDataLo, 32'hDEAD_BEEF);
    finishFrame(25);
    wr(A_ACK, 32'd0);
    rd(A_ACK, v); check(v[25] == 1'b1, "R8 zero write keeps ack", v, 32'd1 << 25);
    wr(A_ACK, 32'd1 << 25);
    rd(A_ACK, v); check(v == 0, "R8 ack clear", v, 0);

    // R9 / R6: enable removed during a busy frame
    wr(mbAddr(2, 1), 32'd1 << 8);
    wr(mbAddr(10, 1), 32'd40 << 8);
    wr(mbAddr(11, 1), 32'd30 << 8);
    wr(A_EN, (32'd1 << 2) | (32'd1 << 10) | (32'd1 << 11));
    wr(A_REQ, 32'd1 << 2);
    waitStart(idx, ok);
    check(ok && idx == 2, "R3 single candidate", 32'(idx), 2);
    wr(A_REQ, (32'd1 << 10) | (32'd1 << 11));
    wr(A_REQ, 32'd0);
    rd(A_REQ, v);
    check(v == ((32'd1 << 2) | (32'd1 << 10) | (32'd1 << 11)), "R2 pending kept", v,
          (32'd1 << 2) | (32'd1 << 10) | (32'd1 << 11));
    wr(A_EN, (32'd1 << 2) | (32'd1 << 11));
    check(txBusy && txIdx == 2 && !txStart, "R6 index held", 32'(txIdx), 2);
    finishFrame(2);
    waitStart(idx, ok);
    check(ok && idx == 11, "R9 disabled mailbox skipped", 32'(idx), 11);
    finishFrame(11);
    repeat (3) @(negedge clk);
    check(!txBusy, "R9 disabled stays out", {31'd0, txBusy}, 0);
    wr(A_EN, 32'd1 << 10);
    waitStart(idx, ok);
    check(ok && idx == 10, "R9 re-enabled competes", 32'(idx), 10);
    finishFrame(10);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R5 direction and enable gating
    wr(mbAddr(9, 1), 32'd50 << 8);
    wr(mbAddr(8, 1), 32'd60 << 8);
    wr(A_DIR, 32'd1 << 9);
    wr(A_EN, 32'd1 << 9);
    wr(A_REQ, (32'd1 << 8) | (32'd1 << 9));
    repeat (5) @(negedge clk);
    check(!txBusy, "R5 receive/disabled not selected", {31'd0, txBusy}, 0);
    wr(A_DIR, 32'd0);
    waitStart(idx, ok);
    check(ok && idx == 9, "R5 transmit direction selected", 32'(idx), 9);
    finishFrame(9);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule